// File: doc/BRIEF.md
# Flash Unlock Command Sequencer

This block sits behind the asynchronous bus pins of a word-wide parallel flash and turns the bus cycles the host writes into operation requests. It brings chip enable, output enable and write enable into the system clock domain. It accepts a write only when the write-enable pulse lasts long enough. It then walks a command state machine through the two-cycle unlock prefix and the command byte that follows it.

A word program takes four writes. Chip erase, block erase, page erase and lockout set take six writes, because the 0x80 setup byte must be followed by a second unlock. The identification mode is a flag. While it is set, the block supplies the manufacturer and device codes for reads at the two lowest addresses. Each completed command produces a one-cycle request that carries an operation code, the captured address and the captured data word. A downstream array controller carries out the request.

A read cycle or a write that breaks the expected order discards a partial sequence. While the array controller reports busy, writes are ignored.

Top module: `flash_cmd_seq`

## Requirements
- R1: A sequence starts with a write of 0xAA to 0x5555 followed by a write of 0x55 to 0x2AAA. All command comparisons use only address bits 14..0 and data bits 7..0, so the higher address and data bits have no effect on decoding.
- R2: After the prefix, 0xA0 at 0x5555 arms a program. The next accepted write produces opKind = 1 (program), with opAddr and opData equal to that write's full address and data.
- R3: After the prefix, 0x80 at 0x5555 must be followed by 0xAA at 0x5555 and 0x55 at 0x2AAA. The sixth write then decides the request: data 0x30 at any address gives opKind = 3 (block erase); data 0x50 at any address gives opKind = 4 (page erase); 0x10 at 0x5555 gives opKind = 2 (chip erase); 0x40 at 0x5555 gives opKind = 5 (lockout set).
- R4: After the prefix, 0x90 at 0x5555 sets idMode without a request. While idMode is set, idWord is 0x00DA at address 0, the device code (default 0x003D) at address 1, and 0x0000 elsewhere. idWord is 0x0000 while idMode is clear. A read cycle does not clear idMode.
- R5: idMode is cleared by the prefix followed by 0xF0 at 0x5555. It is also cleared by a single write of 0xF0 to any address while no sequence is in progress.
- R6: A read cycle (chip enable and output enable both low) during a sequence discards it, so the writes that follow must start a new prefix.
- R7: A write that does not match the next expected step discards the sequence. That write does not start a new sequence, even when it is 0xAA at 0x5555.
- R8: The request address is the bus address at the start of the write-enable low pulse. The request data is the bus data at its end.
- R9: A write whose synchronised write-enable low time is shorter than MIN_WE_CYCLES clock cycles (default 3) is ignored. A pulse of exactly MIN_WE_CYCLES is accepted.
- R10: While busy is high, writes are ignored, any partial sequence is dropped and idMode does not change.
- R11: opValid is low after reset and is a single-cycle pulse. It rises in the third clock cycle after the rising edge of write enable (two synchroniser stages plus one register). Exactly one request is made per completed command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ceN | input | 1 | Chip enable from the bus, active low, asynchronous |
| oeN | input | 1 | Output enable from the bus, active low, asynchronous |
| weN | input | 1 | Write enable from the bus, active low, asynchronous |
| addr | input | 18 | Bus word address |
| data | input | 16 | Bus write data |
| busy | input | 1 | Array controller busy; blocks new commands |
| opValid | output | 1 | One-cycle operation request strobe |
| opKind | output | 3 | Operation code: 1 program, 2 chip erase, 3 block erase, 4 page erase, 5 lockout set |
| opAddr | output | 18 | Address captured for the request |
| opData | output | 16 | Data captured for the request |
| idMode | output | 1 | Identification mode active |
| idWord | output | 16 | Identification word for the current address |

## Verification
A wrong sequence state never shows up at once. It appears only at the next write, either as a request that should not exist, a request that is missing, or a wrong opKind. That happens at the earliest three cycles after the write enable rises on the write that completes a command. The bench therefore ends every abort scenario with a full valid command, which proves the sequencer came back to idle. A wrong identification state shows on idWord at the next read of address 0 or 1. A fault in address or data capture shows only when the bus changes during the pulse, so one erase command moves the address and the data in the middle of the pulse.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    OP_NONE        = 3'd0,
    OP_PROGRAM     = 3'd1,
    OP_CHIP_ERASE  = 3'd2,
    OP_BLOCK_ERASE = 3'd3,
    OP_PAGE_ERASE  = 3'd4,
    OP_LOCK_SET    = 3'd5
  } opKind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_UNL1,
    S_UNL2,
    S_SETUP,
    S_UNL3,
    S_UNL4,
    S_PROG
  } seqState_e;

  typedef struct packed {
    logic    fire;
    opKind_e kind;
    logic    setId;
    logic    clrId;
  } seqStrobe_t;

  localparam int CMP_AW = 15;
  localparam int CMP_DW = 8;

  localparam logic [CMP_AW-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [CMP_AW-1:0] KEY_ADDR_B = 15'h2AAA;

  localparam logic [CMP_DW-1:0] CODE_UNLOCK_A = 8'hAA;
  localparam logic [CMP_DW-1:0] CODE_UNLOCK_B = 8'h55;
  localparam logic [CMP_DW-1:0] CODE_PROGRAM  = 8'hA0;
  localparam logic [CMP_DW-1:0] CODE_SETUP    = 8'h80;
  localparam logic [CMP_DW-1:0] CODE_ID_ENTER = 8'h90;
  localparam logic [CMP_DW-1:0] CODE_ID_EXIT  = 8'hF0;
  localparam logic [CMP_DW-1:0] CODE_CHIP     = 8'h10;
  localparam logic [CMP_DW-1:0] CODE_BLOCK    = 8'h30;
  localparam logic [CMP_DW-1:0] CODE_PAGE     = 8'h50;
  localparam logic [CMP_DW-1:0] CODE_LOCK     = 8'h40;

endpackage

// File: rtl/flash_bus_sampler.sv
module flash_bus_sampler #(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 16,
  parameter int SYNC_STAGES   = 2,
  parameter int MIN_WE_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              wrStrobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              rdStrobe
);

  localparam int CNT_W = $clog2(MIN_WE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_WE_CYCLES);

  logic [SYNC_STAGES-1:0] ceSync, oeSync, weSync;
  logic ceS, oeS, weS;
  logic wrActive, rdActive, wrPrev, rdPrev;
  logic [CNT_W-1:0] widthCnt;
  logic [ADDR_W-1:0] addrHold;

  // Synchroniser chains for the three asynchronous strobes.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceSync <= '1;
      oeSync <= '1;
      weSync <= '1;
    end else begin
      ceSync <= {ceSync[SYNC_STAGES-2:0], ceN};
      oeSync <= {oeSync[SYNC_STAGES-2:0], oeN};
      weSync <= {weSync[SYNC_STAGES-2:0], weN};
    end
  end

  assign ceS = ceSync[SYNC_STAGES-1];
  assign oeS = oeSync[SYNC_STAGES-1];
  assign weS = weSync[SYNC_STAGES-1];

  // A write needs output enable inactive; a read is both enables low.
  assign wrActive = ~ceS & ~weS & oeS;
  assign rdActive = ~ceS & ~oeS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev   <= 1'b0;
      rdPrev   <= 1'b0;
      widthCnt <= '0;
      addrHold <= '0;
    end else begin
      wrPrev <= wrActive;
      rdPrev <= rdActive;
      if (wrActive) begin
        if (!wrPrev) begin
          widthCnt <= CNT_W'(1);
          addrHold <= addr;
        end else if (widthCnt != CNT_MIN) begin
          widthCnt <= widthCnt + CNT_W'(1);
        end
      end
    end
  end

  // End of pulse: address from the start, data from the bus now.
  assign wrStrobe = wrPrev & ~wrActive & (widthCnt >= CNT_MIN);
  assign wrAddr   = addrHold;
  assign wrData   = data;
  assign rdStrobe = rdActive & ~rdPrev;

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [CMP_AW-1:0] cmpAddr,
  input  logic [CMP_DW-1:0] cmpData,
  input  logic              rdStrobe,
  input  logic              busy,
  input  logic              idMode,
  output seqStrobe_t        strobe
);

  seqState_e state, nxt;
  logic atKeyA, atKeyB;

  assign atKeyA = (cmpAddr == KEY_ADDR_A);
  assign atKeyB = (cmpAddr == KEY_ADDR_B);

  always_comb begin
    nxt    = state;
    strobe = '0;
    if (busy) begin
      nxt = S_IDLE;
    end else if (rdStrobe) begin
      nxt = S_IDLE;
    end else if (wrStrobe) begin
      unique case (state)
        S_IDLE: begin
          if (idMode && cmpData == CODE_ID_EXIT) strobe.clrId = 1'b1;
          else if (atKeyA && cmpData == CODE_UNLOCK_A) nxt = S_UNL1;
        end
        S_UNL1:  nxt = (atKeyB && cmpData == CODE_UNLOCK_B) ? S_UNL2 : S_IDLE;
        S_UNL2: begin
          nxt = S_IDLE;
          if (atKeyA) begin
            case (cmpData)
              CODE_PROGRAM:  nxt = S_PROG;
              CODE_SETUP:    nxt = S_SETUP;
              CODE_ID_ENTER: strobe.setId = 1'b1;
              CODE_ID_EXIT:  strobe.clrId = 1'b1;
              default:       nxt = S_IDLE;
            endcase
          end
        end
        S_SETUP: nxt = (atKeyA && cmpData == CODE_UNLOCK_A) ? S_UNL3 : S_IDLE;
        S_UNL3:  nxt = (atKeyB && cmpData == CODE_UNLOCK_B) ? S_UNL4 : S_IDLE;
        S_UNL4: begin
          nxt = S_IDLE;
          if (cmpData == CODE_BLOCK) begin
            strobe.fire = 1'b1;
            strobe.kind = OP_BLOCK_ERASE;
          end else if (cmpData == CODE_PAGE) begin
            strobe.fire = 1'b1;
            strobe.kind = OP_PAGE_ERASE;
          end else if (atKeyA && cmpData == CODE_CHIP) begin
            strobe.fire = 1'b1;
            strobe.kind = OP_CHIP_ERASE;
          end else if (atKeyA && cmpData == CODE_LOCK) begin
            strobe.fire = 1'b1;
            strobe.kind = OP_LOCK_SET;
          end
        end
        S_PROG: begin
          nxt         = S_IDLE;
          strobe.fire = 1'b1;
          strobe.kind = OP_PROGRAM;
        end
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

endmodule

// File: rtl/flash_seq_datapath.sv
module flash_seq_datapath
  import flash_seq_pkg::*;
#(
  parameter int              ADDR_W   = 18,
  parameter int              DATA_W   = 16,
  parameter logic [15:0]     MFR_CODE = 16'h00DA,
  parameter logic [15:0]     DEV_CODE = 16'h003D
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] addr,
  output logic              opValid,
  output logic [2:0]        opKind,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData,
  output logic              idMode,
  output logic [DATA_W-1:0] idWord
);

  localparam logic [ADDR_W-1:0] ADDR_MFR = '0;
  localparam logic [ADDR_W-1:0] ADDR_DEV = ADDR_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opValid <= 1'b0;
      opKind  <= OP_NONE;
      opAddr  <= '0;
      opData  <= '0;
      idMode  <= 1'b0;
    end else begin
      opValid <= strobe.fire;
      if (strobe.fire) begin
        opKind <= strobe.kind;
        opAddr <= wrAddr;
        opData <= wrData;
      end
      if (strobe.setId)      idMode <= 1'b1;
      else if (strobe.clrId) idMode <= 1'b0;
    end
  end

  always_comb begin
    idWord = '0;
    if (idMode) begin
      if (addr == ADDR_MFR)      idWord = DATA_W'(MFR_CODE);
      else if (addr == ADDR_DEV) idWord = DATA_W'(DEV_CODE);
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int          ADDR_W        = 18,
  parameter int          DATA_W        = 16,
  parameter int          SYNC_STAGES   = 2,
  parameter int          MIN_WE_CYCLES = 3,
  parameter logic [15:0] MFR_CODE      = 16'h00DA,
  parameter logic [15:0] DEV_CODE      = 16'h003D
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              busy,
  output logic              opValid,
  output logic [2:0]        opKind,
  output logic [ADDR_W-1:0] opAddr,
  output logic [DATA_W-1:0] opData,
  output logic              idMode,
  output logic [DATA_W-1:0] idWord
);

  logic              wrStrobe, rdStrobe;
  logic [ADDR_W-1:0] wrAddr;
  logic [DATA_W-1:0] wrData;
  seqStrobe_t        strobe;

  flash_bus_sampler #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .SYNC_STAGES(SYNC_STAGES), .MIN_WE_CYCLES(MIN_WE_CYCLES)
  ) uSampler (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .data(data),
    .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData), .rdStrobe(rdStrobe)
  );

  flash_seq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe),
    .cmpAddr(wrAddr[CMP_AW-1:0]), .cmpData(wrData[CMP_DW-1:0]),
    .rdStrobe(rdStrobe), .busy(busy), .idMode(idMode), .strobe(strobe)
  );

  flash_seq_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr), .wrData(wrData),
    .addr(addr), .opValid(opValid), .opKind(opKind), .opAddr(opAddr),
    .opData(opData), .idMode(idMode), .idWord(idWord)
  );

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int          ADDR_W   = 18,
  parameter int          DATA_W   = 16,
  parameter logic [15:0] MFR_CODE = 16'h00DA,
  parameter logic [15:0] DEV_CODE = 16'h003D
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic [ADDR_W-1:0] addr,
  input logic              opValid,
  input logic [2:0]        opKind,
  input logic              idMode,
  input logic [DATA_W-1:0] idWord
);

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> !opValid); // R11

  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    opValid |-> (opKind >= 3'd1 && opKind <= 3'd5)); // R3

  AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !opValid); // R10

  AST_BUSY_ID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(idMode)); // R10

  AST_ID_ENTRY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idMode) |-> !opValid); // R4

  AST_ID_EXIT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $fell(idMode) |-> !opValid); // R5

  AST_ID_MFR: assert property (@(posedge clk) disable iff (!rstN)
    (idMode && addr == '0) |-> idWord == DATA_W'(MFR_CODE)); // R4

  AST_ID_DEV: assert property (@(posedge clk) disable iff (!rstN)
    (idMode && addr == ADDR_W'(1)) |-> idWord == DATA_W'(DEV_CODE)); // R4

  AST_ID_QUIET_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !idMode |-> idWord == '0); // R4

endmodule

bind flash_cmd_seq flash_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
) uChk (
  .clk(clk), .rstN(rstN), .busy(busy), .addr(addr), .opValid(opValid),
  .opKind(opKind), .idMode(idMode), .idWord(idWord)
);

// File: tb/sim_flash_cmd_seq.sv
`timescale 1ns/1ps
module sim_flash_cmd_seq;

  localparam int MINW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1, busy = 1'b0;
  logic [17:0] addr = '0;
  logic [15:0] data = '0;
  logic opValid, idMode;
  logic [2:0] opKind;
  logic [17:0] opAddr;
  logic [15:0] opData, idWord;

  int checks = 0, errors = 0;
  int pulsesSeen = 0, pulsesExp = 0;
  bit done = 1'b0;

  // behavioural model state
  logic [14:0] qA[$];
  logic [7:0]  qD[$];
  bit mId = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_seq #(.MIN_WE_CYCLES(MINW)) u0 (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN), .addr(addr),
    .data(data), .busy(busy), .opValid(opValid), .opKind(opKind),
    .opAddr(opAddr), .opData(opData), .idMode(idMode), .idWord(idWord)
  );

  always @(negedge clk) if (rstN && opValid) pulsesSeen++;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void dropSeq();
    qA.delete();
    qD.delete();
  endfunction

  // Returns the expected operation code for an accepted write (0 = none).
  function automatic int modelWrite(input logic [17:0] a, input logic [15:0] d);
    logic [14:0] ka = a[14:0];
    logic [7:0]  kd = d[7:0];
    int n;
    int res = 0;
    if (busy) begin dropSeq(); return 0; end
    if (qA.size() == 0 && mId && kd == 8'hF0) begin mId = 1'b0; return 0; end
    qA.push_back(ka);
    qD.push_back(kd);
    n = qA.size();
    if (n == 1) begin
      if (!(ka == 15'h5555 && kd == 8'hAA)) dropSeq();
    end else if (n == 2) begin
      if (!(ka == 15'h2AAA && kd == 8'h55)) dropSeq();
    end else if (n == 3) begin
      if (ka != 15'h5555) dropSeq();
      else if (kd == 8'h90) begin mId = 1'b1; dropSeq(); end
      else if (kd == 8'hF0) begin mId = 1'b0; dropSeq(); end
      else if (kd != 8'hA0 && kd != 8'h80) dropSeq();
    end else if (n == 4) begin
      if (qD[2] == 8'hA0) begin res = 1; dropSeq(); end
      else if (!(ka == 15'h5555 && kd == 8'hAA)) dropSeq();
    end else if (n == 5) begin
      if (!(ka == 15'h2AAA && kd == 8'h55)) dropSeq();
    end else begin
      if (kd == 8'h30) res = 3;
      else if (kd == 8'h50) res = 4;
      else if (ka == 15'h5555 && kd == 8'h10) res = 2;
      else if (ka == 15'h5555 && kd == 8'h40) res = 5;
      dropSeq();
    end
    return res;
  endfunction

  task automatic doWrite(input logic [17:0] a, input logic [15:0] d, input int lowCyc,
                         input bit perturb, input logic [17:0] aMid, input string req);
    int expK;
    @(negedge clk);
    addr = a; data = perturb ? ~d : d; ceN = 1'b0; oeN = 1'b1;
    @(negedge clk);
    weN = 1'b0;
    for (int i = 1; i < lowCyc; i++) begin
      @(negedge clk);
      if (perturb && i == 3) addr = aMid;
      if (perturb && i == lowCyc - 1) data = d;
    end
    @(negedge clk);
    weN = 1'b1;
    expK = (lowCyc >= MINW) ? modelWrite(a, d) : 0;
    if (expK != 0) pulsesExp++;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk(opValid == (expK != 0), req, "opValid at third cycle", 32'(opValid), 32'(expK != 0));
    if (expK != 0) begin
      chk(opKind == 3'(expK), req, "opKind", 32'(opKind), 32'(expK));
      chk(opAddr == a, req, "opAddr", 32'(opAddr), 32'(a));
      chk(opData == d, req, "opData", 32'(opData), 32'(d));
    end
    @(negedge clk);
    chk(opValid == 1'b0, "R11", "opValid after pulse", 32'(opValid), 32'd0);
    chk(idMode == mId, req, "idMode", 32'(idMode), 32'(mId));
    ceN = 1'b1;
    @(negedge clk);
  endtask

  task automatic w(input logic [17:0] a, input logic [15:0] d, input string req);
    doWrite(a, d, 6, 1'b0, a, req);
  endtask

  task automatic doRead(input logic [17:0] a, input string req);
    logic [15:0] exp;
    @(negedge clk);
    addr = a; ceN = 1'b0; oeN = 1'b0;
    dropSeq();
    repeat (3) @(negedge clk);
    exp = !mId ? 16'h0000 : (a == 18'd0) ? 16'h00DA : (a == 18'd1) ? 16'h003D : 16'h0000;
    chk(idWord == exp, req, "idWord", 32'(idWord), 32'(exp));
    chk(opValid == 1'b0, req, "no request on read", 32'(opValid), 32'd0);
    oeN = 1'b1; ceN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic prefix(input string req);
    w(18'h05555, 16'h00AA, req);
    w(18'h02AAA, 16'h0055, req);
  endtask

  task automatic eraseCmd(input logic [17:0] a, input logic [15:0] d, input string req);
    prefix(req);
    w(18'h05555, 16'h0080, req);
    prefix(req);
    w(a, d, req);
  endtask

  task automatic finishUp();
    chk(pulsesSeen == pulsesExp, "R11", "request count", 32'(pulsesSeen), 32'(pulsesExp));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      finishUp();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R11 reset state
    chk(opValid == 1'b0, "R11", "reset opValid", 32'(opValid), 32'd0);
    chk(idMode == 1'b0, "R4", "reset idMode", 32'(idMode), 32'd0);
    chk(idWord == 16'h0, "R4", "reset idWord", 32'(idWord), 32'd0);

    // R2 program
    prefix("R2"); w(18'h05555, 16'h00A0, "R2"); w(18'h1F00C, 16'h1234, "R2");
    // R1 upper address/data bits ignored in comparisons
    w(18'h3D555, 16'hFFAA, "R1"); w(18'h2AAAA, 16'h8055, "R1");
    w(18'h15555, 16'h77A0, "R1"); w(18'h3FFFF, 16'hBEEF, "R1");

    // R3 all six-cycle commands
    eraseCmd(18'h05555, 16'h0010, "R3");
    eraseCmd(18'h08000, 16'h0050, "R3");
    eraseCmd(18'h05555, 16'h0040, "R3");
    eraseCmd(18'h01234, 16'h0040, "R3"); // lockout code away from key address: none
    // R8 block erase with address moved and data settled late in the pulse
    prefix("R8"); w(18'h05555, 16'h0080, "R8"); prefix("R8");
    doWrite(18'h12000, 16'h0030, 6, 1'b1, 18'h00777, "R8");

    // R4 identification entry and reads
    prefix("R4"); w(18'h05555, 16'h0090, "R4");
    doRead(18'd0, "R4"); doRead(18'd1, "R4"); doRead(18'd2, "R4");
    // R5 single-cycle exit at an arbitrary address
    w(18'h01234, 16'h00F0, "R5");
    doRead(18'd0, "R5");
    // R5 three-cycle exit
    prefix("R4"); w(18'h05555, 16'h0090, "R4");
    prefix("R5"); w(18'h05555, 16'h00F0, "R5");
    doRead(18'd1, "R5");

    // R6 read inside a sequence aborts it
    prefix("R6"); doRead(18'h00100, "R6");
    w(18'h05555, 16'h00A0, "R6"); w(18'h00200, 16'h4444, "R6");
    prefix("R6"); w(18'h05555, 16'h00A0, "R6"); w(18'h00200, 16'h4444, "R6");

    // R7 invalid writes abort and do not restart
    w(18'h05555, 16'h00AA, "R7"); w(18'h05555, 16'h00AA, "R7");
    w(18'h02AAA, 16'h0055, "R7"); w(18'h05555, 16'h00A0, "R7"); w(18'h00300, 16'h0001, "R7");
    prefix("R7"); w(18'h05555, 16'h0077, "R7"); w(18'h05555, 16'h00A0, "R7");
    eraseCmd(18'h05555, 16'h0010, "R7");

    // R9 pulse width: too short ignored, exact minimum accepted
    prefix("R9");
    doWrite(18'h05555, 16'h00A0, MINW - 1, 1'b0, 18'h0, "R9");
    doWrite(18'h05555, 16'h00A0, MINW, 1'b0, 18'h0, "R9");
    doWrite(18'h00400, 16'h5A5A, MINW, 1'b0, 18'h0, "R9");

    // R10 busy blocks, drops partial sequence, holds idMode
    @(negedge clk); busy = 1'b1;
    prefix("R10"); w(18'h05555, 16'h00A0, "R10"); w(18'h00500, 16'h0F0F, "R10");
    @(negedge clk); busy = 1'b0; dropSeq();
    prefix("R10");
    @(negedge clk); busy = 1'b1; repeat (4) @(negedge clk); busy = 1'b0; dropSeq();
    w(18'h05555, 16'h00A0, "R10"); w(18'h00500, 16'h0F0F, "R10");
    prefix("R4"); w(18'h05555, 16'h0090, "R4");
    @(negedge clk); busy = 1'b1;
    w(18'h00000, 16'h00F0, "R10");
    @(negedge clk); busy = 1'b0; dropSeq();
    chk(idMode == 1'b1, "R10", "idMode kept under busy", 32'(idMode), 32'd1);
    w(18'h00000, 16'h00F0, "R5");

    repeat (4) @(negedge clk);
    done = 1'b1;
    finishUp();
  end

endmodule